// File: doc/BRIEF.md
# External Bus Read-Ahead Buffer Controller

This block sits between a CPU and a slow external memory region and reads ahead sequentially into a small byte queue. Once a CPU read supplies a start address, the controller keeps issuing read bursts on a simple external-bus master port. Each burst uses the configured bus width and burst length. Returned beats are packed into the queue, and CPU reads that land on the head of the queue are answered in the same cycle.

A fill is issued only when the queue has room for a whole burst unit. A burst is cut short at the edge of its aligned block. A CPU read that misses flushes the queue and restarts the read-ahead at the miss address. A write observed on the snoop port that touches buffered or in-flight bytes flushes the queue and halts read-ahead. Another bus master's request is granted only between bursts, and it also holds off new fills. A global enable input pauses fills for accesses to regions where read-ahead is not wanted.

Top module: `xbus_prefetch`

## Requirements
- R1: While and after reset the queue is empty and the read-ahead address is invalid, so the first CPU read reports a miss. `busy`, `bus_req`, `ext_gnt` and `cpu_rd_hit` are 0.
- R2: `cfg_width` encodes 0/1/2 as an 8/16/32-bit bus. `cfg_burst` encodes 0/1/2/3 as 1/2/4/8 beats. One fill unit is width-bytes times beats, capped at the queue depth (16 bytes). A burst length of 1 gives single one-beat accesses.
- R3: A fill is issued only when the queue depth minus the bytes buffered or in flight is at least one full fill unit. With a 16-bit bus and 8 beats, a new fill waits until the queue is empty.
- R4: A burst never crosses the block aligned to the fill unit. Its beat count shrinks to the bytes left up to the block end, so a 16-bit, 2-beat fill starting at offset 0xE issues 1 beat.
- R5: The first burst after a miss starts at the miss address rounded down to the bus width. Bytes below the miss address are dropped and not queued.
- R6: `cpu_rd_size` encodes 0/1/2 (3 also reads 4 bytes) as a 1/2/4-byte read. A read at the head address with enough queued bytes raises `cpu_rd_hit` in the same cycle. It returns the bytes little-endian in `cpu_rd_data`, with unused upper lanes at zero, and frees them.
- R7: A read not at the head address raises `cpu_rd_miss`, empties the queue and restarts read-ahead at that address. A read at the head with too few bytes raises `cpu_rd_wait` and neither hit nor miss.
- R8: `ext_gnt` is given to `ext_req` only while no burst is in progress. A pending `ext_req` prevents a new fill from being issued.
- R9: `bus_req` is a one-cycle pulse carrying `bus_addr` and `bus_beats`. `busy` is high from that cycle until the cycle that takes `bus_done`.
- R10: A snoop write whose address lies in the buffered or in-flight range flushes the queue and stops read-ahead until the next miss. A snoop write outside that range has no effect.
- R11: When a snoop hit and a CPU read fall in the same cycle, the read is reported as a miss and read-ahead restarts at the read address.
- R12: While `pf_enable` is low no new fill is issued. Queued bytes are still served.
- R13: Beats still arriving from a burst that was flushed part-way are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Bus width select (0: 8, 1: 16, 2: 32 bits) |
| cfg_burst | input | 2 | Burst length select (0: 1, 1: 2, 2: 4, 3: 8 beats) |
| pf_enable | input | 1 | Allows new fills when high |
| cpu_rd_req | input | 1 | CPU read request |
| cpu_rd_addr | input | AW | CPU read byte address |
| cpu_rd_size | input | 2 | Read size (0: 1, 1: 2, 2/3: 4 bytes) |
| cpu_rd_hit | output | 1 | Read served from the queue this cycle |
| cpu_rd_miss | output | 1 | Read missed; queue flushed |
| cpu_rd_wait | output | 1 | Read at head, bytes not yet arrived |
| cpu_rd_data | output | 32 | Little-endian read data, valid with hit |
| snp_wr_valid | input | 1 | Observed write strobe |
| snp_wr_addr | input | AW | Observed write byte address |
| ext_req | input | 1 | Other master asks for the external bus |
| ext_gnt | output | 1 | Bus granted to the other master |
| bus_req | output | 1 | Burst request pulse |
| bus_addr | output | AW | Burst start byte address |
| bus_beats | output | 4 | Beats in the burst |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | 32 | Read beat data, byte lane i at address+i |
| bus_done | input | 1 | Last beat of the burst |
| busy | output | 1 | Burst in progress |

## Verification
The function pair that can collide in one cycle is a snoop-write invalidation and a CPU read at the queue head. The bench fills the queue, drives a snoop address inside the held range together with a read of the head byte, and expects a miss instead of a hit. It then expects the next burst request to carry the read address. A second collision, a miss arriving while a burst is still returning beats, is judged by reading at the new address and checking that the returned byte belongs to the new address, not to the stale burst.

// File: rtl/xpf_pkg.sv
package xpf_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [1:0] wsel;
        logic [1:0] bsel;
    } cfg_t;

    typedef struct packed {
        logic        en;
        logic [31:0] data;
        logic [1:0]  skip;
        logic [2:0]  nbytes;
    } push_t;

    function automatic logic [2:0] wbytes(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] wshift(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [5:0] unit_bytes(input logic [1:0] wsel,
                                              input logic [1:0] bsel,
                                              input logic [5:0] cap);
        logic [5:0] u;
        u = 6'(wbytes(wsel)) << bsel;
        return (u > cap) ? cap : u;
    endfunction

    function automatic logic [3:0] burst_beats(input logic [5:0] unit,
                                               input logic [4:0] addr_lo,
                                               input logic [1:0] wsel);
        logic [5:0] off;
        logic [5:0] len;
        off = {1'b0, addr_lo} & (unit - 6'd1);
        len = unit - off;
        return 4'(len >> wshift(wsel));
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/xpf_store.sv
module xpf_store
    import xpf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          pop_en,
    input  logic [2:0]    pop_bytes,
    input  push_t         push,
    output logic [31:0]   head_word,
    output logic [CW-1:0] count
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;
    logic [31:0]   shifted;

    assign shifted = push.data >> {push.skip, 3'b000};
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (push.en && (3'(k) < push.nbytes))
                mem[wr_ptr + PW'(k)] <= shifted[8*k +: 8];
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
            assign head_word[8*k +: 8] = mem[rd_ptr + PW'(k)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop_en)
                rd_ptr <= rd_ptr + PW'(pop_bytes);
            if (push.en)
                wr_ptr <= wr_ptr + PW'(push.nbytes);
            cnt_q <= cnt_q - (pop_en ? CW'(pop_bytes) : CW'(0))
                           + (push.en ? CW'(push.nbytes) : CW'(0));
        end
    end

    // R3: the queue never holds more bytes than its depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R6: a pop never takes more bytes than are queued
    p_pop_avail_r6: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> (CW'(pop_bytes) <= cnt_q));

endmodule

// File: rtl/xpf_fetch_fsm.sv
module xpf_fetch_fsm
    import xpf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    wsel,
    input  logic [5:0]    unit,
    input  logic          issue_ok,
    input  logic          ext_req,
    input  logic          flush,
    input  logic [AW-1:0] fetch_addr,
    input  logic          bus_rvalid,
    input  logic          bus_done,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [3:0]    bus_beats,
    output logic          busy,
    output logic          ext_gnt,
    output logic          issue,
    output logic [5:0]    issue_len,
    output logic          beat_take,
    output logic [AW-1:0] beat_addr
);

    fsm_e          st;
    logic          discard;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] baddr_q;
    logic [3:0]    beats_q;
    logic [3:0]    nbeats;

    assign nbeats    = burst_beats(unit, fetch_addr[4:0], wsel);
    assign issue     = (st == ST_IDLE) && issue_ok && !ext_req && !flush;
    assign issue_len = 6'(nbeats) << wshift(wsel);
    assign ext_gnt   = ext_req && (st == ST_IDLE);
    assign busy      = (st != ST_IDLE);
    assign bus_req   = (st == ST_REQ);
    assign bus_addr  = addr_q;
    assign bus_beats = beats_q;
    assign beat_take = (st == ST_DATA) && bus_rvalid && !discard && !flush;
    assign beat_addr = baddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            discard <= 1'b0;
            addr_q  <= '0;
            baddr_q <= '0;
            beats_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (issue) begin
                        st      <= ST_REQ;
                        addr_q  <= fetch_addr;
                        baddr_q <= fetch_addr;
                        beats_q <= nbeats;
                    end
                end
                ST_REQ: begin
                    st <= ST_DATA;
                    if (flush)
                        discard <= 1'b1;
                end
                ST_DATA: begin
                    if (bus_rvalid)
                        baddr_q <= baddr_q + AW'(wbytes(wsel));
                    if (bus_done) begin
                        st      <= ST_IDLE;
                        discard <= 1'b0;
                    end else if (flush) begin
                        discard <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: the request is a single-cycle pulse
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> !bus_req);

    // R8: no burst is issued in the cycle after a pending external request
    p_no_issue_ext_r8: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !$past(ext_req));

    // R2: beat count is within 1..8
    p_beats_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_beats != 4'd0 && bus_beats <= 4'd8));

    // R4: a burst ends at or before its aligned block edge
    p_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ((({1'b0, bus_addr[4:0]} & (unit - 6'd1))
                      + (6'(bus_beats) << wshift(wsel))) <= unit));

endmodule

// File: rtl/xbus_prefetch.sv
module xbus_prefetch
    import xpf_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_width,
    input  logic [1:0]    cfg_burst,
    input  logic          pf_enable,
    input  logic          cpu_rd_req,
    input  logic [AW-1:0] cpu_rd_addr,
    input  logic [1:0]    cpu_rd_size,
    output logic          cpu_rd_hit,
    output logic          cpu_rd_miss,
    output logic          cpu_rd_wait,
    output logic [31:0]   cpu_rd_data,
    input  logic          snp_wr_valid,
    input  logic [AW-1:0] snp_wr_addr,
    input  logic          ext_req,
    output logic          ext_gnt,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [3:0]    bus_beats,
    input  logic          bus_rvalid,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_done,
    output logic          busy
);

    cfg_t          cfg;
    logic [5:0]    unit;
    logic [2:0]    wb;
    logic [2:0]    rd_bytes;
    logic [AW-1:0] head_q;
    logic [AW-1:0] nfetch_q;
    logic          pf_valid_q;
    logic [AW-1:0] occ_raw;
    logic [AW-1:0] occ;
    logic          snp_hit;
    logic          at_head;
    logic          enough;
    logic          flush;
    logic          issue_ok;
    logic          issue;
    logic [5:0]    issue_len;
    logic          beat_take;
    logic [AW-1:0] beat_addr;
    logic [AW-1:0] dlt;
    logic [1:0]    skip;
    push_t         push;
    logic [CW-1:0] count;
    logic [31:0]   head_word;

    assign cfg      = '{wsel: cfg_width, bsel: cfg_burst};
    assign unit     = unit_bytes(cfg.wsel, cfg.bsel, 6'(DEPTH));
    assign wb       = wbytes(cfg.wsel);
    assign rd_bytes = size_bytes(cpu_rd_size);

    // bytes buffered or in flight; zero while the fetch pointer trails the head
    assign occ_raw  = nfetch_q - head_q;
    assign occ      = occ_raw[AW-1] ? '0 : occ_raw;

    assign snp_hit  = snp_wr_valid && pf_valid_q && ((snp_wr_addr - head_q) < occ);
    assign at_head  = pf_valid_q && (cpu_rd_addr == head_q);
    assign enough   = (count >= CW'(rd_bytes));

    assign cpu_rd_hit  = cpu_rd_req && at_head && enough && !snp_hit;
    assign cpu_rd_wait = cpu_rd_req && at_head && !enough && !snp_hit;
    assign cpu_rd_miss = cpu_rd_req && !(at_head && !snp_hit);
    assign flush       = cpu_rd_miss || snp_hit;

    assign issue_ok = pf_valid_q && pf_enable && ((occ + AW'(unit)) <= AW'(DEPTH));

    always_comb begin
        case (cpu_rd_size)
            2'd0:    cpu_rd_data = {24'd0, head_word[7:0]};
            2'd1:    cpu_rd_data = {16'd0, head_word[15:0]};
            default: cpu_rd_data = head_word;
        endcase
        if (!cpu_rd_hit)
            cpu_rd_data = '0;
    end

    // leading bytes of a beat that lie below the head are dropped
    assign dlt  = head_q - beat_addr;
    assign skip = (dlt < AW'(wb)) ? dlt[1:0] : 2'd0;

    always_comb begin
        push.en     = beat_take;
        push.data   = bus_rdata;
        push.skip   = skip;
        push.nbytes = wb - {1'b0, skip};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            nfetch_q   <= '0;
            pf_valid_q <= 1'b0;
        end else if (flush) begin
            if (cpu_rd_miss) begin
                head_q     <= cpu_rd_addr;
                nfetch_q   <= cpu_rd_addr & ~(AW'(wb) - AW'(1));
                pf_valid_q <= 1'b1;
            end else begin
                pf_valid_q <= 1'b0;
            end
        end else begin
            if (cpu_rd_hit)
                head_q <= head_q + AW'(rd_bytes);
            if (issue)
                nfetch_q <= nfetch_q + AW'(issue_len);
        end
    end

    xpf_fetch_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wsel       (cfg.wsel),
        .unit       (unit),
        .issue_ok   (issue_ok),
        .ext_req    (ext_req),
        .flush      (flush),
        .fetch_addr (nfetch_q),
        .bus_rvalid (bus_rvalid),
        .bus_done   (bus_done),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_beats  (bus_beats),
        .busy       (busy),
        .ext_gnt    (ext_gnt),
        .issue      (issue),
        .issue_len  (issue_len),
        .beat_take  (beat_take),
        .beat_addr  (beat_addr)
    );

    xpf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .pop_en    (cpu_rd_hit),
        .pop_bytes (rd_bytes),
        .push      (push),
        .head_word (head_word),
        .count     (count)
    );

    // R7: a miss leaves the queue empty in the next cycle
    p_miss_empties_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_miss |=> (count == '0));

    // R10: a snoop hit without a read halts read-ahead
    p_snoop_halts_r10: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && !cpu_rd_req) |=> !pf_valid_q);

    // R12: while disabled and idle, no burst starts
    p_disabled_r12: assert property (@(posedge clk) disable iff (rst)
        (!pf_enable && !busy) |=> !busy);

    // R3: a request is only out when buffered plus in-flight bytes fit
    p_space_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (occ <= AW'(DEPTH)));

endmodule

// File: tb/xbus_prefetch_bench.sv
module xbus_prefetch_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_width = 2'd1;
    logic [1:0]    cfg_burst = 2'd1;
    logic          pf_enable = 1'b1;
    logic          cpu_rd_req = 1'b0;
    logic [AW-1:0] cpu_rd_addr = '0;
    logic [1:0]    cpu_rd_size = 2'd0;
    logic          cpu_rd_hit, cpu_rd_miss, cpu_rd_wait;
    logic [31:0]   cpu_rd_data;
    logic          snp_wr_valid = 1'b0;
    logic [AW-1:0] snp_wr_addr = '0;
    logic          ext_req = 1'b0;
    logic          ext_gnt;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_beats;
    logic          bus_rvalid = 1'b0;
    logic [31:0]   bus_rdata = '0;
    logic          bus_done = 1'b0;
    logic          busy;

    always #2 clk = ~clk;

    xbus_prefetch #(.AW(AW), .DEPTH(16)) u_xbus_prefetch (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_burst(cfg_burst),
        .pf_enable(pf_enable), .cpu_rd_req(cpu_rd_req), .cpu_rd_addr(cpu_rd_addr),
        .cpu_rd_size(cpu_rd_size), .cpu_rd_hit(cpu_rd_hit), .cpu_rd_miss(cpu_rd_miss),
        .cpu_rd_wait(cpu_rd_wait), .cpu_rd_data(cpu_rd_data), .snp_wr_valid(snp_wr_valid),
        .snp_wr_addr(snp_wr_addr), .ext_req(ext_req), .ext_gnt(ext_gnt), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_beats(bus_beats), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .bus_done(bus_done), .busy(busy)
    );

    int n_chk  = 0;
    int n_fail = 0;

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory responder: one idle cycle after the request, then back-to-back beats
    int            rem = 0;
    logic [AW-1:0] maddr = '0;
    int            req_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [3:0]    last_beats = '0;
    logic          busy_at_req = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            rem = 0; bus_rvalid = 1'b0; bus_done = 1'b0;
        end else begin
            bus_rvalid = 1'b0;
            bus_done   = 1'b0;
            if (rem != 0) begin
                bus_rvalid = 1'b1;
                for (int i = 0; i < 4; i++) bus_rdata[8*i +: 8] = mb(maddr + 32'(i));
                maddr = maddr + (32'd1 << cfg_width);
                rem--;
                bus_done = (rem == 0);
            end
            if (bus_req) begin
                rem         = int'(bus_beats);
                maddr       = bus_addr;
                req_cnt++;
                last_addr   = bus_addr;
                last_beats  = bus_beats;
                busy_at_req = busy;
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic do_reset(input logic [1:0] w, input logic [1:0] b);
        @(negedge clk);
        rst = 1'b1; cfg_width = w; cfg_burst = b; pf_enable = 1'b1;
        cpu_rd_req = 1'b0; snp_wr_valid = 1'b0; ext_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic cpu_read(input logic [31:0] a, input logic [1:0] sz,
                            output logic hit, output logic miss,
                            output logic wt, output logic [31:0] data);
        @(negedge clk);
        cpu_rd_req = 1'b1; cpu_rd_addr = a; cpu_rd_size = sz;
        #1;
        hit = cpu_rd_hit; miss = cpu_rd_miss; wt = cpu_rd_wait; data = cpu_rd_data;
        @(posedge clk);
        #1 cpu_rd_req = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a);
        @(negedge clk);
        snp_wr_valid = 1'b1; snp_wr_addr = a;
        @(posedge clk);
        #1 snp_wr_valid = 1'b0;
    endtask

    task automatic wait_req(input string tag, output logic seen);
        int start;
        start = req_cnt;
        seen  = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #1;
            if (req_cnt != start) begin seen = 1'b1; break; end
        end
        check(tag, "burst request seen", 32'(seen), 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
    endfunction

    typedef struct packed {
        logic [1:0]  w;
        logic [1:0]  b;
        logic [31:0] a;
        logic [31:0] ea;
        logic [3:0]  eb;
    } vec_t;

    // width sel, burst sel, miss address, expected burst address, expected beats
    localparam vec_t VECS [7] = '{
        '{2'd1, 2'd1, 32'h0000_0100, 32'h0000_0100, 4'd2},
        '{2'd1, 2'd1, 32'h0000_010E, 32'h0000_010E, 4'd1},
        '{2'd0, 2'd3, 32'h0000_0203, 32'h0000_0203, 4'd5},
        '{2'd2, 2'd0, 32'h0000_0301, 32'h0000_0300, 4'd1},
        '{2'd1, 2'd3, 32'h0000_0400, 32'h0000_0400, 4'd8},
        '{2'd2, 2'd3, 32'h0000_0500, 32'h0000_0500, 4'd4},
        '{2'd2, 2'd2, 32'h0000_0508, 32'h0000_0508, 4'd2}
    };

    initial begin
        logic        h, m, wt, seen;
        logic [31:0] d;
        int          snap;

        // R1: reset state
        do_reset(2'd1, 2'd1);
        @(negedge clk); #1;
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "bus_req after reset", 32'(bus_req), 32'd0);
        check("R1", "ext_gnt after reset", 32'(ext_gnt), 32'd0);
        check("R1", "cpu_rd_hit idle", 32'(cpu_rd_hit), 32'd0);

        // R2 R4 R5 R6 R9: vector table walk
        foreach (VECS[i]) begin
            do_reset(VECS[i].w, VECS[i].b);
            cpu_read(VECS[i].a, 2'd0, h, m, wt, d);
            check("R1", "first read misses", 32'(m), 32'd1);
            wait_req("R2", seen);
            check("R5", "burst address", last_addr, VECS[i].ea);
            check("R4", "burst beats", 32'(last_beats), 32'(VECS[i].eb));
            check("R9", "busy with request", 32'(busy_at_req), 32'd1);
            idle(20);
            cpu_read(VECS[i].a, 2'd0, h, m, wt, d);
            check("R6", "head read hit", 32'(h), 32'd1);
            check("R6", "head read byte", d, {24'd0, mb(VECS[i].a)});
        end

        // R3: 16-bit, 8 beats: next fill waits for an empty queue
        do_reset(2'd1, 2'd3);
        cpu_read(32'h400, 2'd0, h, m, wt, d);
        wait_req("R3", seen);
        idle(25);
        snap = req_cnt;
        cpu_read(32'h400, 2'd2, h, m, wt, d);
        check("R6", "4-byte read little-endian", d, word_at(32'h400));
        idle(10);
        check("R3", "no fill with 4 free bytes", 32'(req_cnt), 32'(snap));
        cpu_read(32'h404, 2'd1, h, m, wt, d);
        check("R6", "2-byte read", d, {16'd0, word_at(32'h404)[15:0]});
        cpu_read(32'h406, 2'd2, h, m, wt, d);
        cpu_read(32'h40A, 2'd2, h, m, wt, d);
        idle(6);
        check("R3", "no fill with 14 free bytes", 32'(req_cnt), 32'(snap));
        cpu_read(32'h40E, 2'd1, h, m, wt, d);
        check("R6", "last 2 bytes hit", 32'(h), 32'd1);
        wait_req("R3", seen);
        check("R3", "refill address after empty", last_addr, 32'h410);
        check("R3", "refill beats", 32'(last_beats), 32'd8);

        // R7: read at head before bytes arrive waits
        do_reset(2'd0, 2'd0);
        cpu_read(32'h600, 2'd0, h, m, wt, d);
        cpu_read(32'h600, 2'd2, h, m, wt, d);
        check("R7", "wait flag", 32'(wt), 32'd1);
        check("R7", "no hit while waiting", 32'(h), 32'd0);
        check("R7", "no miss while waiting", 32'(m), 32'd0);

        // R8: external request waits for the burst and blocks new fills
        do_reset(2'd0, 2'd3);
        cpu_read(32'h800, 2'd0, h, m, wt, d);
        wait_req("R8", seen);
        @(negedge clk);
        ext_req = 1'b1;
        #1;
        check("R8", "no grant during burst", 32'(ext_gnt), 32'd0);
        check("R9", "busy during burst", 32'(busy), 32'd1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (!busy) break;
        end
        check("R8", "grant after burst", 32'(ext_gnt), 32'd1);
        snap = req_cnt;
        idle(10);
        check("R8", "no fill while ext pending", 32'(req_cnt), 32'(snap));
        @(negedge clk);
        ext_req = 1'b0;
        wait_req("R8", seen);
        check("R8", "fill resumes address", last_addr, 32'h808);

        // R13: miss part-way through a burst discards its remaining beats
        do_reset(2'd0, 2'd3);
        cpu_read(32'h700, 2'd0, h, m, wt, d);
        wait_req("R13", seen);
        cpu_read(32'h900, 2'd0, h, m, wt, d);
        check("R7", "new address misses", 32'(m), 32'd1);
        wait_req("R13", seen);
        check("R7", "restart at miss address", last_addr, 32'h900);
        idle(20);
        cpu_read(32'h900, 2'd2, h, m, wt, d);
        check("R13", "data from new address", d, word_at(32'h900));

        // R10: snoop writes
        do_reset(2'd1, 2'd1);
        cpu_read(32'hA00, 2'd0, h, m, wt, d);
        idle(40);
        snoop(32'hA20);
        cpu_read(32'hA00, 2'd0, h, m, wt, d);
        check("R10", "outside snoop keeps data", 32'(h), 32'd1);
        check("R10", "outside snoop data", d, {24'd0, mb(32'hA00)});
        snoop(32'hA06);
        snap = req_cnt;
        idle(20);
        check("R10", "no fill after snoop hit", 32'(req_cnt), 32'(snap));
        cpu_read(32'hA01, 2'd0, h, m, wt, d);
        check("R10", "head read misses after snoop", 32'(m), 32'd1);

        // R11: snoop hit and read in the same cycle
        do_reset(2'd1, 2'd1);
        cpu_read(32'hB00, 2'd0, h, m, wt, d);
        idle(40);
        @(negedge clk);
        snp_wr_valid = 1'b1; snp_wr_addr = 32'hB02;
        cpu_rd_req = 1'b1; cpu_rd_addr = 32'hB00; cpu_rd_size = 2'd0;
        #1;
        h = cpu_rd_hit; m = cpu_rd_miss;
        @(posedge clk);
        #1 snp_wr_valid = 1'b0; cpu_rd_req = 1'b0;
        check("R11", "collision gives miss", 32'(m), 32'd1);
        check("R11", "collision gives no hit", 32'(h), 32'd0);
        wait_req("R11", seen);
        check("R11", "restart at read address", last_addr, 32'hB00);

        // R12: fills paused while disabled
        do_reset(2'd1, 2'd1);
        @(negedge clk);
        pf_enable = 1'b0;
        cpu_read(32'hC00, 2'd0, h, m, wt, d);
        snap = req_cnt;
        idle(15);
        check("R12", "no fill while disabled", 32'(req_cnt), 32'(snap));
        check("R12", "idle while disabled", 32'(busy), 32'd0);
        @(negedge clk);
        pf_enable = 1'b1;
        wait_req("R12", seen);
        check("R12", "fill after enable", last_addr, 32'hC00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule